// File: doc/BRIEF.md
# Sorting-Network Population Counter

This block counts the ones in a word of N = 2^K − 1 bits and returns the count as a K-bit binary number. The supported sizes are 7 bits to 3, 15 bits to 4 and 31 bits to 5. Because N is the largest value that K bits can hold, the count never overflows. The block does not use a tree of full adders. Instead it sorts the input bits so that every one ends up on the low-numbered wires. The sorted word is a thermometer code. Each boundary between ones and zeros in that code is marked by a one-hot flag, and the flags are ORed together into the binary count.

The input word is split into two segments of unequal size. The lower segment holds 2^(K−1) − 1 data bits, and a constant zero pads it to a power of two. The upper segment holds 2^(K−1) data bits. Each segment is sorted on its own, and an odd-even merge then joins the two sorted halves. Every compare-exchange element places the OR of its two bits on the lower wire and the AND on the upper wire.

The parameter `PIPE` selects how the block is built. With `PIPE = 0` the sorting network is purely combinational. With `PIPE = 1` there is one register after each compare-exchange layer. The output is always registered. A valid flag travels alongside the data with the same delay.

Top module: `popsort_counter`

## Requirements
- R1: `cnt_o` equals the number of ones in the `bits_i` word that was sampled `LAT` cycles earlier, for K = 3, 4 and 5.
- R2: The latency `LAT` is 1 + PIPE·K·(K+1)/2 clock cycles. This gives 1 for the combinational build, and 7, 11 or 16 for the staged build with K = 3, 4 or 5.
- R3: `vld_o` is `vld_i` delayed by `LAT` cycles. The count path runs every cycle whatever the state of `vld_i`, so `cnt_o` follows `bits_i` even while the valid flag is low.
- R4: While `rst` is high at a rising edge, every register is cleared. In the cycle after such an edge, `vld_o` = 0 and `cnt_o` = 0. A reset in the middle of a stream discards every word still in flight.
- R5: An all-zero word counts 0, and an all-ones word counts N (= 2^K − 1). A single one counts 1 at any bit position. A word with exactly one zero counts N − 1 wherever that zero sits.
- R6: The block accepts a new word on every clock cycle with no gaps. Results come out in input order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Marks `bits_i` as carrying a word of interest |
| bits_i | input | N = 2^K−1 | Bits to be counted |
| vld_o | output | 1 | `vld_i` delayed by the block latency |
| cnt_o | output | K | Number of ones in the matching input word |

## Verification
The assertions assume that `bits_i` and `vld_i` hold known values at every rising edge where `rst` is low. They also assume that `rst` is held high from time zero until at least one edge has passed. Given those conditions, the assertions check the following: every layer keeps the number of ones unchanged, the network output is a thermometer code, the decoder produces exactly one flag, and each staged layer delays the valid flag by exactly one cycle. The bench meets these assumptions in three ways. It starts in reset. It changes inputs only on falling edges. It drives all-zero words with the valid flag low whenever it is idle, so no unknown value ever reaches the network.

// File: rtl/popsort_pkg.sv
package popsort_pkg;

  // Number of compare-exchange layers in a full odd-even merge sort
  // over 2^k wires.
  function automatic int layer_count(input int k);
    return k * (k + 1) / 2;
  endfunction

  // Layer s belongs to the merge round whose block half-size is 2^pe,
  // and compares wires 2^ke apart.  Rounds run pe = 0..k-1; inside a
  // round the distance shrinks from 2^pe down to 1.
  function automatic int layer_pe(input int k, input int s);
    int n;
    int res;
    n = 0;
    res = 0;
    for (int pe = 0; pe < k; pe++) begin
      for (int ke = pe; ke >= 0; ke--) begin
        if (n == s) res = pe;
        n++;
      end
    end
    return res;
  endfunction

  function automatic int layer_ke(input int k, input int s);
    int n;
    int res;
    n = 0;
    res = 0;
    for (int pe = 0; pe < k; pe++) begin
      for (int ke = pe; ke >= 0; ke--) begin
        if (n == s) res = ke;
        n++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/cx_layer.sv
// One layer of single-bit compare-exchange elements of an odd-even
// merge sort over M wires, optionally followed by a register.
module cx_layer #(
  parameter int M   = 8,
  parameter int PE  = 0,
  parameter int KE  = 0,
  parameter int REG = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_in,
  input  logic [M-1:0] d_in,
  output logic         v_out,
  output logic [M-1:0] d_out
);
  localparam int P  = 1 << PE;
  localparam int KK = 1 << KE;
  localparam int J0 = KK % P;

  logic [M-1:0] x;

  // Ones move toward wire 0: the lower wire takes the OR, the upper the AND.
  always_comb begin
    x = d_in;
    for (int j = J0; j + KK < M; j += 2 * KK) begin
      for (int i = 0; i < KK; i++) begin
        if ((i + j + KK < M) && ((i + j) / (2 * P) == (i + j + KK) / (2 * P))) begin
          x[i + j]      = d_in[i + j] | d_in[i + j + KK];
          x[i + j + KK] = d_in[i + j] & d_in[i + j + KK];
        end
      end
    end
  end

  // Compare-exchange never creates or destroys a one.
  assert_layer_keeps_ones_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(x) == $countones(d_in));

  generate
    if (REG != 0) begin : g_reg
      logic         v_q;
      logic [M-1:0] d_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else begin
          v_q <= v_in;
          d_q <= x;
        end
      end
      assign v_out = v_q;
      assign d_out = d_q;

      assert_layer_valid_delay_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (v_out == $past(v_in)));
    end else begin : g_comb
      assign v_out = v_in;
      assign d_out = x;
    end
  endgenerate

endmodule

// File: rtl/merge_sorter.sv
// Full odd-even merge sorter over 2^K wires.  The early rounds sort the
// two halves independently; the final round merges them.
module merge_sorter
  import popsort_pkg::*;
#(
  parameter int K    = 3,
  parameter int PIPE = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_v,
  input  logic [(1<<K)-1:0]   in_d,
  output logic                out_v,
  output logic [(1<<K)-1:0]   out_d
);
  localparam int M = 1 << K;
  localparam int S = layer_count(K);

  logic [M-1:0] w [0:S];
  logic         v [0:S];

  assign w[0] = in_d;
  assign v[0] = in_v;

  generate
    for (genvar s = 0; s < S; s++) begin : g_layer
      cx_layer #(
        .M  (M),
        .PE (layer_pe(K, s)),
        .KE (layer_ke(K, s)),
        .REG(PIPE)
      ) u_layer (
        .clk  (clk),
        .rst  (rst),
        .v_in (v[s]),
        .d_in (w[s]),
        .v_out(v[s+1]),
        .d_out(w[s+1])
      );
    end
  endgenerate

  assign out_d = w[S];
  assign out_v = v[S];

  // A sorted single-bit word is a run of ones from wire 0: t+1 is a power of two.
  assert_sorted_thermometer_R1: assert property (@(posedge clk) disable iff (rst)
    ((out_d + 1'b1) & out_d) == '0);

endmodule

// File: rtl/therm_to_bin.sv
// Thermometer (ones from wire 0) to one-hot to binary.
module therm_to_bin #(
  parameter int K = 3
) (
  input  logic [(1<<K)-1:0] therm,
  output logic [(1<<K)-1:0] onehot,
  output logic [K-1:0]      count
);
  localparam int N = (1 << K) - 1;

  // Flag j marks the edge between a one at j-1 and a zero at j; wire N is always 0.
  always_comb begin
    onehot[0] = ~therm[0];
    for (int j = 1; j <= N; j++) begin
      onehot[j] = therm[j-1] & ~therm[j];
    end
  end

  generate
    for (genvar b = 0; b < K; b++) begin : g_bit
      always_comb begin
        count[b] = 1'b0;
        for (int j = 1; j <= N; j++) begin
          if (((j >> b) & 1) == 1) count[b] = count[b] | onehot[j];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/popsort_counter.sv
module popsort_counter
  import popsort_pkg::*;
#(
  parameter int K    = 3,
  parameter int PIPE = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vld_i,
  input  logic [(1<<K)-2:0]   bits_i,
  output logic                vld_o,
  output logic [K-1:0]        cnt_o
);
  localparam int M  = 1 << K;
  localparam int N  = M - 1;
  localparam int NA = M / 2 - 1;  // data bits in the short (padded) segment

  logic [M-1:0] padded;
  logic [M-1:0] sorted;
  logic [M-1:0] onehot;
  logic [K-1:0] count;
  logic         sorted_v;

  // Short segment on wires 0..NA-1 plus a zero pad on wire NA;
  // long segment on wires M/2..M-1.
  assign padded = {bits_i[N-1:NA], 1'b0, bits_i[NA-1:0]};

  merge_sorter #(
    .K   (K),
    .PIPE(PIPE)
  ) u_sort (
    .clk  (clk),
    .rst  (rst),
    .in_v (vld_i),
    .in_d (padded),
    .out_v(sorted_v),
    .out_d(sorted)
  );

  therm_to_bin #(
    .K(K)
  ) u_dec (
    .therm (sorted),
    .onehot(onehot),
    .count (count)
  );

  assert_single_flag_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(onehot) == 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      cnt_o <= '0;
    end else begin
      vld_o <= sorted_v;
      cnt_o <= count;
    end
  end

  assert_reset_clears_R4: assert property (@(posedge clk)
    rst |=> (!vld_o && cnt_o == '0));

endmodule

// File: tb/popsort_counter_tb.sv
`timescale 1ns/1ps
module popsort_counter_tb;

  localparam int L3 = 1;        // K=3, combinational
  localparam int L4 = 1 + 10;   // K=4, staged
  localparam int L5 = 1 + 15;   // K=5, staged

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        v3, v4, v5;
  logic [6:0]  d3;
  logic [14:0] d4;
  logic [30:0] d5;
  logic        ov3, ov4, ov5;
  logic [2:0]  oc3;
  logic [3:0]  oc4;
  logic [4:0]  oc5;

  logic        nv3, nv4, nv5;
  logic [6:0]  nd3;
  logic [14:0] nd4;
  logic [30:0] nd5;

  int q3[$];
  int q4[$];
  int q5[$];
  int errors = 0;
  int checks = 0;
  string tag = "R4";

  popsort_counter #(.K(4), .PIPE(1)) u_dut (
    .clk(clk), .rst(rst), .vld_i(v4), .bits_i(d4), .vld_o(ov4), .cnt_o(oc4));
  popsort_counter #(.K(3), .PIPE(0)) u_dut_k3 (
    .clk(clk), .rst(rst), .vld_i(v3), .bits_i(d3), .vld_o(ov3), .cnt_o(oc3));
  popsort_counter #(.K(5), .PIPE(1)) u_dut_k5 (
    .clk(clk), .rst(rst), .vld_i(v5), .bits_i(d5), .vld_o(ov5), .cnt_o(oc5));

  task automatic chk(input string req, input string who, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got valid=%0d count=%0d, expected valid=%0d count=%0d",
               req, who, act / 256, act % 256, exp / 256, exp % 256);
    end
  endtask

  // One cycle: at the falling edge compare what is due, then apply next inputs.
  task automatic step();
    int e;
    @(negedge clk);
    rst = 1'b0;
    if (q3.size() == L3) begin e = q3.pop_front(); chk(tag, "k3", int'(ov3) * 256 + int'(oc3), e); end
    if (q4.size() == L4) begin e = q4.pop_front(); chk(tag, "k4", int'(ov4) * 256 + int'(oc4), e); end
    if (q5.size() == L5) begin e = q5.pop_front(); chk(tag, "k5", int'(ov5) * 256 + int'(oc5), e); end
    v3 = nv3; d3 = nd3; q3.push_back(int'(nv3) * 256 + $countones(nd3));
    v4 = nv4; d4 = nd4; q4.push_back(int'(nv4) * 256 + $countones(nd4));
    v5 = nv5; d5 = nd5; q5.push_back(int'(nv5) * 256 + $countones(nd5));
  endtask

  task automatic idle(input int n);
    nv3 = 0; nv4 = 0; nv5 = 0; nd3 = '0; nd4 = '0; nd5 = '0;
    for (int i = 0; i < n; i++) step();
  endtask

  // R4: reset with busy inputs forces zero outputs and flushes the pipeline.
  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    v3 = 1; v4 = 1; v5 = 1; d3 = '1; d4 = '1; d5 = '1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4", "k3", int'(ov3) * 256 + int'(oc3), 0);
      chk("R4", "k4", int'(ov4) * 256 + int'(oc4), 0);
      chk("R4", "k5", int'(ov5) * 256 + int'(oc5), 0);
    end
    q3.delete(); q4.delete(); q5.delete();
    v3 = 0; v4 = 0; v5 = 0; d3 = '0; d4 = '0; d5 = '0;
  endtask

  // R5: all zero, all ones, walking one, walking zero.
  task automatic t_extremes();
    tag = "R5";
    nv3 = 1; nv4 = 1; nv5 = 1;
    nd3 = '0; nd4 = '0; nd5 = '0; step();
    nd3 = '1; nd4 = '1; nd5 = '1; step();
    for (int b = 0; b < 31; b++) begin
      nd3 = 7'(1) << (b % 7); nd4 = 15'(1) << (b % 15); nd5 = 31'(1) << b;
      step();
      nd3 = ~nd3; nd4 = ~nd4; nd5 = ~nd5;
      step();
    end
    idle(L5 + 1);
  endtask

  // R1 and R6: every 7- and 15-bit word back to back, random 31-bit words.
  task automatic t_exhaustive();
    tag = "R1 R6";
    nv3 = 1; nv4 = 1; nv5 = 1;
    for (int i = 0; i < 32768; i++) begin
      nd3 = i[6:0];
      nd4 = i[14:0];
      nd5 = {$urandom()}[30:0];
      step();
    end
    idle(L5 + 1);
  endtask

  // R3: valid gaps travel with the data; counts still follow idle-flagged words.
  task automatic t_valid_gaps();
    tag = "R3";
    for (int i = 0; i < 300; i++) begin
      nv3 = (i % 3) != 1; nv4 = (i % 4) == 0; nv5 = (i % 5) > 1;
      nd3 = {$urandom()}[6:0]; nd4 = {$urandom()}[14:0]; nd5 = {$urandom()}[30:0];
      step();
    end
    idle(L5 + 1);
  endtask

  // R2: a lone valid word appears exactly LAT cycles later.
  task automatic t_latency();
    int f3, f4, f5;
    tag = "R2";
    f3 = 0; f4 = 0; f5 = 0;
    idle(L5 + 2);
    nv3 = 1; nv4 = 1; nv5 = 1; nd3 = 7'h15; nd4 = 15'h0F0F; nd5 = 31'h1234_5678;
    step();
    nv3 = 0; nv4 = 0; nv5 = 0; nd3 = '0; nd4 = '0; nd5 = '0;
    for (int j = 1; j <= L5 + 3; j++) begin
      step();
      if (ov3 && f3 == 0) f3 = j;
      if (ov4 && f4 == 0) f4 = j;
      if (ov5 && f5 == 0) f5 = j;
    end
    chk("R2", "k3 latency", f3, L3);
    chk("R2", "k4 latency", f4, L4);
    chk("R2", "k5 latency", f5, L5);
  endtask

  initial begin
    v3 = 0; v4 = 0; v5 = 0; d3 = '0; d4 = '0; d5 = '0;
    nv3 = 0; nv4 = 0; nv5 = 0; nd3 = '0; nd4 = '0; nd5 = '0;
    t_reset();
    t_extremes();
    t_latency();
    t_valid_gaps();
    t_reset();          // mid-run reset, R4
    t_exhaustive();
    t_latency();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got no end, expected finish within 200000 cycles");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule